// File: doc/BRIEF.md
# Lock-Step Multi-Cycle Pipeline Sequencer

This block is the control unit of an in-order CPU pipeline in which every stage may spend several clock cycles on one instruction. Each stage reports, by a done pulse or level, that its work on the current instruction is finished. The sequencer remembers those reports and moves all inter-stage registers forward together, in one cycle, once every occupied stage has finished. No stage ever moves on by itself. The stage that takes longest, usually the memory stage, therefore sets the issue rate.

The sequencer keeps a valid bit per stage. Reset fills the whole pipeline with bubbles, and an empty stage counts as finished. When the pipeline advances, each stage that receives a real instruction gets a one-cycle start pulse. A new instruction is taken into the first stage through a simple fetch handshake. A flush request names a stage. Every younger stage, meaning every stage nearer the front, is then dropped on the next advance. A minimum spacing between advances models the shortest stage latency, so with every stage at its minimum the pipeline completes one instruction every `MIN_GAP` cycles (four by default). A saturating debug counter totals the cycles lost to busy stages.

Top module: `psq_seq`

## Requirements
- R1: While reset is asserted and directly after it is released, `stage_valid` and `stage_start` are all zero and `cpi_count` is zero.
- R2: A done report from a valid stage is remembered until the next advance. `advance` is high only when every valid, unflushed stage has reported done since its last start, or reports done in the current cycle.
- R3: On an advance, bit i+1 of `stage_valid` takes the old bit i (minus flushed stages), bit 0 takes `ifetch_valid`, and the old top bit leaves the pipeline. Bit 0 is the fetch stage and the highest bit is the oldest stage.
- R4: In the cycle after an advance, `stage_start` equals the new `stage_valid`. In every other cycle it is zero.
- R5: Two advances are at least `MIN_GAP` cycles apart, and with all stages done they are exactly `MIN_GAP` apart. The first advance after reset may happen in the first cycle.
- R6: A `flush_req` with `flush_src` = s marks stages 0 to s-1. On the next advance, their instructions do not move on. A marked stage no longer holds the pipeline, and the mark lasts until that advance even if the request was only one cycle long.
- R7: `ifetch_take` is high exactly in an advance cycle with `ifetch_valid` high. An advance with `ifetch_valid` low puts a bubble into stage 0.
- R8: `cpi_count` increases by one at the end of each cycle in which some valid, unflushed stage has not reported done and no advance happens. It does not change otherwise, and it saturates at all ones.
- R9: `stage_valid` does not change in a cycle without an advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stage_done | input | N_STAGES | Per-stage work-finished report |
| flush_req | input | 1 | Request to drop instructions younger than `flush_src` |
| flush_src | input | $clog2(N_STAGES) | Index of the stage requesting the flush |
| ifetch_valid | input | 1 | An instruction is offered to the fetch stage |
| ifetch_take | output | 1 | The offered instruction is accepted this cycle |
| advance | output | 1 | All pipeline registers move forward this cycle |
| stage_start | output | N_STAGES | One-cycle start pulse per stage holding a new instruction |
| stage_valid | output | N_STAGES | Occupancy bit per stage |
| cpi_count | output | CPI_W | Saturating count of stall cycles caused by busy stages |

## Verification
A lost or stuck done record shows at the ports in one of two ways: `advance` fires while a stage is still busy, or the pipeline hangs with `cpi_count` climbing every cycle. Either appears within one advance period. A wrong flush mark shows as a wrong `stage_valid` pattern in the cycle right after the next advance. A spacing timer that is off by one moves the advance edge by a cycle, and the bench catches that on the first interval it measures. Errors in the valid shift or the start pulses become visible one cycle after the faulty advance.

// File: rtl/psq_pkg.sv
package psq_pkg;
   localparam int DEF_STAGES = 5;
   localparam int DEF_GAP    = 4;
   localparam int DEF_CPI_W  = 16;

   // Per-stage condition seen by the advance logic
   typedef enum logic [1:0] {
      ST_EMPTY  = 2'd0,
      ST_BUSY   = 2'd1,
      ST_DONE   = 2'd2,
      ST_KILLED = 2'd3
   } stage_st_e;
endpackage

// File: rtl/psq_done_track.sv
module psq_done_track #(
   parameter int N_STAGES = psq_pkg::DEF_STAGES
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [N_STAGES-1:0] stage_done,
   input  logic [N_STAGES-1:0] stage_valid,
   input  logic [N_STAGES-1:0] kill_mask,
   input  logic                advance,
   output logic [N_STAGES-1:0] ready,
   output logic [N_STAGES-1:0] busy
);
   logic [N_STAGES-1:0] done_q;

   for (genvar i = 0; i < N_STAGES; i++) begin : g_stage
      psq_pkg::stage_st_e st;

      always_ff @(posedge clk) begin
         if (!rst_n || advance)
            done_q[i] <= 1'b0;
         else if (stage_valid[i] && stage_done[i])
            done_q[i] <= 1'b1;
      end

      always_comb begin
         if (!stage_valid[i])
            st = psq_pkg::ST_EMPTY;
         else if (kill_mask[i])
            st = psq_pkg::ST_KILLED;
         else if (done_q[i] || stage_done[i])
            st = psq_pkg::ST_DONE;
         else
            st = psq_pkg::ST_BUSY;
      end

      assign ready[i] = (st != psq_pkg::ST_BUSY);
      assign busy[i]  = (st == psq_pkg::ST_BUSY);
   end
endmodule

// File: rtl/psq_kill_ctl.sv
module psq_kill_ctl #(
   parameter int N_STAGES = psq_pkg::DEF_STAGES,
   parameter int SRC_W    = $clog2(N_STAGES)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                flush_req,
   input  logic [SRC_W-1:0]    flush_src,
   input  logic                advance,
   output logic [N_STAGES-1:0] kill_mask
);
   logic [N_STAGES-1:0] req_mask;
   logic [N_STAGES-1:0] kill_q;

   for (genvar i = 0; i < N_STAGES; i++) begin : g_req
      assign req_mask[i] = flush_req && (i < int'(flush_src));
   end

   always_ff @(posedge clk) begin
      if (!rst_n || advance)
         kill_q <= '0;
      else
         kill_q <= kill_q | req_mask;
   end

   assign kill_mask = kill_q | req_mask;
endmodule

// File: rtl/psq_gap_timer.sv
module psq_gap_timer #(
   parameter int MIN_GAP = psq_pkg::DEF_GAP
) (
   input  logic clk,
   input  logic rst_n,
   input  logic advance,
   output logic gap_ok
);
   if (MIN_GAP <= 1) begin : g_free
      assign gap_ok = 1'b1;
   end else begin : g_count
      localparam int GW = $clog2(MIN_GAP);
      localparam logic [GW-1:0] LIM = GW'(MIN_GAP - 1);
      logic [GW-1:0] cnt_q;

      always_ff @(posedge clk) begin
         if (!rst_n)
            cnt_q <= LIM;
         else if (advance)
            cnt_q <= '0;
         else if (cnt_q != LIM)
            cnt_q <= cnt_q + 1'b1;
      end

      assign gap_ok = (cnt_q == LIM);
   end
endmodule

// File: rtl/psq_seq.sv
module psq_seq #(
   parameter int N_STAGES = psq_pkg::DEF_STAGES,
   parameter int MIN_GAP  = psq_pkg::DEF_GAP,
   parameter int CPI_W    = psq_pkg::DEF_CPI_W,
   localparam int SRC_W   = $clog2(N_STAGES)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [N_STAGES-1:0] stage_done,
   input  logic                flush_req,
   input  logic [SRC_W-1:0]    flush_src,
   input  logic                ifetch_valid,
   output logic                ifetch_take,
   output logic                advance,
   output logic [N_STAGES-1:0] stage_start,
   output logic [N_STAGES-1:0] stage_valid,
   output logic [CPI_W-1:0]    cpi_count
);
   if (N_STAGES < 2) begin : g_bad_stages
      $error("psq_seq: N_STAGES must be at least 2");
   end
   if (MIN_GAP < 1) begin : g_bad_gap
      $error("psq_seq: MIN_GAP must be at least 1");
   end
   if (CPI_W < 1) begin : g_bad_cpi
      $error("psq_seq: CPI_W must be at least 1");
   end

   logic [N_STAGES-1:0] ready, busy, kill_mask;
   logic [N_STAGES-1:0] valid_q, start_q, next_valid;
   logic [CPI_W-1:0]    cpi_q;
   logic                gap_ok;

   psq_done_track #(.N_STAGES(N_STAGES)) u_done (
      .clk(clk), .rst_n(rst_n), .stage_done(stage_done),
      .stage_valid(valid_q), .kill_mask(kill_mask), .advance(advance),
      .ready(ready), .busy(busy)
   );

   psq_kill_ctl #(.N_STAGES(N_STAGES), .SRC_W(SRC_W)) u_kill (
      .clk(clk), .rst_n(rst_n), .flush_req(flush_req),
      .flush_src(flush_src), .advance(advance), .kill_mask(kill_mask)
   );

   psq_gap_timer #(.MIN_GAP(MIN_GAP)) u_gap (
      .clk(clk), .rst_n(rst_n), .advance(advance), .gap_ok(gap_ok)
   );

   assign advance     = (&ready) & gap_ok;
   assign ifetch_take = advance & ifetch_valid;
   assign next_valid  = {valid_q[N_STAGES-2:0] & ~kill_mask[N_STAGES-2:0], ifetch_valid};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= '0;
         start_q <= '0;
      end else begin
         if (advance)
            valid_q <= next_valid;
         start_q <= advance ? next_valid : '0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         cpi_q <= '0;
      else if ((|busy) && !advance && (cpi_q != '1))
         cpi_q <= cpi_q + 1'b1;
   end

   assign stage_valid = valid_q;
   assign stage_start = start_q;
   assign cpi_count   = cpi_q;
endmodule

// File: rtl/psq_seq_chk.sv
module psq_seq_chk #(
   parameter int N_STAGES = 5,
   parameter int MIN_GAP  = 4,
   parameter int CPI_W    = 16
) (
   input logic                clk,
   input logic                rst_n,
   input logic                ifetch_valid,
   input logic                ifetch_take,
   input logic                advance,
   input logic [N_STAGES-1:0] stage_start,
   input logic [N_STAGES-1:0] stage_valid,
   input logic [CPI_W-1:0]    cpi_count
);
   int   since_adv;
   logic seen_adv;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         since_adv <= 0;
         seen_adv  <= 1'b0;
      end else if (advance) begin
         since_adv <= 0;
         seen_adv  <= 1'b1;
      end else if (since_adv < MIN_GAP) begin
         since_adv <= since_adv + 1;
      end
   end

   // R5: advances keep the minimum spacing
   a_r5_min_spacing: assert property (@(posedge clk) disable iff (!rst_n)
      (advance && seen_adv) |-> (since_adv >= MIN_GAP - 1));

   // R4: a start pulse only follows an advance
   a_r4_start_after_adv: assert property (@(posedge clk) disable iff (!rst_n)
      (|stage_start) |-> $past(advance));

   // R3: an instruction only reaches a stage from the stage before it
   a_r3_shift_source: assert property (@(posedge clk) disable iff (!rst_n)
      advance |=> ((stage_valid[N_STAGES-1:1] & ~$past(stage_valid[N_STAGES-2:0])) == '0));

   // R7: fetch stage is loaded from the fetch handshake
   a_r7_entry: assert property (@(posedge clk) disable iff (!rst_n)
      advance |=> (stage_valid[0] == $past(ifetch_valid)));

   // R7: acceptance needs an advance and an offer
   a_r7_take_cond: assert property (@(posedge clk) disable iff (!rst_n)
      ifetch_take |-> (advance && ifetch_valid));

   // R9: occupancy holds between advances
   a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !advance |=> (stage_valid == $past(stage_valid)));

   // R8: the stall counter moves by single steps
   a_r8_cpi_step: assert property (@(posedge clk) disable iff (!rst_n)
      (cpi_count != $past(cpi_count)) |-> (cpi_count == $past(cpi_count) + 1'b1));

   // R8: an advance cycle is not a stall
   a_r8_cpi_frozen_on_adv: assert property (@(posedge clk) disable iff (!rst_n)
      advance |=> (cpi_count == $past(cpi_count)));
endmodule

bind psq_seq psq_seq_chk #(
   .N_STAGES(N_STAGES), .MIN_GAP(MIN_GAP), .CPI_W(CPI_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .ifetch_valid(ifetch_valid),
   .ifetch_take(ifetch_take), .advance(advance), .stage_start(stage_start),
   .stage_valid(stage_valid), .cpi_count(cpi_count)
);

// File: tb/psq_seq_tb_top.sv
`timescale 1ns/1ps
module psq_seq_tb_top;
   localparam int N  = 5;
   localparam int SW = $clog2(N);
   localparam int CW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [N-1:0]  stage_done = '0;
   logic          flush_req = 1'b0;
   logic [SW-1:0] flush_src = '0;
   logic          ifetch_valid = 1'b0;
   logic          ifetch_take, advance;
   logic [N-1:0]  stage_start, stage_valid;
   logic [CW-1:0] cpi_count;

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;

   always #2 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   psq_seq #(.N_STAGES(N), .MIN_GAP(4), .CPI_W(CW)) dut_i (
      .clk(clk), .rst_n(rst_n), .stage_done(stage_done), .flush_req(flush_req),
      .flush_src(flush_src), .ifetch_valid(ifetch_valid), .ifetch_take(ifetch_take),
      .advance(advance), .stage_start(stage_start), .stage_valid(stage_valid),
      .cpi_count(cpi_count)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic next_cycle();
      @(posedge clk);
      #1;
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      stage_done = '0;
      flush_req = 1'b0;
      flush_src = '0;
      ifetch_valid = 1'b0;
      repeat (3) @(posedge clk);
      #1;
      chk("R1 valid in reset", 32'(stage_valid), 0);
      rst_n = 1'b1;
   endtask

   task automatic wait_adv(output int n);
      n = 0;
      while (!advance && n < 50) begin
         next_cycle();
         n++;
      end
   endtask

   // fill the pipeline with all stages finishing at once; returns just after the 5th advance edge
   task automatic fill_all();
      int n;
      do_reset();
      ifetch_valid = 1'b1;
      stage_done = '1;
      #1;
      for (int k = 0; k < N; k++) begin
         wait_adv(n);
         next_cycle();
      end
   endtask

   task automatic t_reset();
      do_reset();
      #1;
      chk("R1 valid after release", 32'(stage_valid), 0);
      chk("R1 start after release", 32'(stage_start), 0);
      chk("R1 cpi after release", 32'(cpi_count), 0);
      chk("R5 first advance immediate", 32'(advance), 1);
      chk("R7 no take without offer", 32'(ifetch_take), 0);
      next_cycle();
      chk("R7 bubble enters", 32'(stage_valid), 0);
   endtask

   task automatic t_fill();
      int n, last;
      logic [N-1:0] exp;
      do_reset();
      ifetch_valid = 1'b1;
      stage_done = '1;
      #1;
      chk("R7 take on advance", 32'(ifetch_take), 1);
      last = cyc;
      for (int k = 1; k <= 6; k++) begin
         if (k > 1) begin
            wait_adv(n);
            chk("R5 advance interval", 32'(cyc - last), 4);
            last = cyc;
         end
         next_cycle();
         exp = (k >= N) ? '1 : N'((1 << k) - 1);
         chk("R3 valid shift", 32'(stage_valid), 32'(exp));
         chk("R4 start pulse", 32'(stage_start), 32'(exp));
         next_cycle();
         chk("R4 start one cycle", 32'(stage_start), 0);
         chk("R9 valid held", 32'(stage_valid), 32'(exp));
      end
   endtask

   task automatic t_slow_stage();
      logic [CW-1:0] c0;
      fill_all();
      c0 = cpi_count;
      stage_done = 5'b10111;      // stage 3 (memory) stays busy
      #1;
      chk("R2 busy stage holds", 32'(advance), 0);
      for (int j = 1; j <= 11; j++) begin
         next_cycle();
         stage_done = '0;
         #1;
         chk("R2 no advance while busy", 32'(advance), 0);
      end
      next_cycle();
      chk("R8 stall cycles counted", 32'(cpi_count), 32'(c0 + 12));
      stage_done = 5'b01000;      // only the slow stage reports now
      #1;
      chk("R2 earlier reports remembered", 32'(advance), 1);
      next_cycle();
      chk("R8 advance not counted", 32'(cpi_count), 32'(c0 + 12));
      chk("R3 full after advance", 32'(stage_valid), 32'h1f);
      stage_done = '1;
   endtask

   task automatic t_flush();
      int n;
      logic [CW-1:0] c0;
      fill_all();
      c0 = cpi_count;
      stage_done = 5'b11000;      // stages 0..2 never finish
      flush_req = 1'b1;
      flush_src = SW'(3);
      #1;
      chk("R5 gap after advance", 32'(advance), 0);
      next_cycle();
      flush_req = 1'b0;
      #1;
      wait_adv(n);
      chk("R6 flushed stages do not hold", 32'(n), 2);
      chk("R8 flushed stages not stalls", 32'(cpi_count), 32'(c0));
      next_cycle();
      chk("R6 younger stages dropped", 32'(stage_valid), 32'h11);
      chk("R4 start after flush", 32'(stage_start), 32'h11);
   endtask

   task automatic t_bubble();
      int n;
      logic pat [3] = '{1'b1, 1'b0, 1'b1};
      do_reset();
      stage_done = '1;
      for (int k = 0; k < 3; k++) begin
         ifetch_valid = pat[k];
         #1;
         wait_adv(n);
         chk("R7 take follows offer", 32'(ifetch_take), 32'(pat[k]));
         next_cycle();
      end
      chk("R7 bubble in pipeline", 32'(stage_valid), 32'h05);
   endtask

   task automatic report();
      $display("%0d/%0d checks passed", checks - fails, checks);
   endtask

   initial begin
      t_reset();
      t_fill();
      t_slow_stage();
      t_flush();
      t_bubble();
      report();
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog actual=expired expected=finished");
      report();
      $finish;
   end
endmodule